// File: doc/BRIEF.md
# SDRAM Burst Column and Byte-Mask Unit

This block drives the column side of a single SDRAM burst on a 32-bit data bus. A command scheduler loads it with a start column, a read/write flag and an auto-precharge flag. From then on it produces one column address per clock. The order of those columns comes from the burst length and burst order held in its own copy of the mode register. Early-stop inputs and a restarting load can cut a burst short.

The block also handles the per-byte masks. On a write beat, a byte lane is enabled only when its mask bit is low in the same cycle. On reads, each pad output enable follows the mask value captured two clocks earlier, so the lane is high-impedance when that mask was high. When a fixed-length burst ends by itself and auto precharge was requested, the block raises a one-cycle request for the scheduler.

Top module: `sdram_burst_colmask`

## Requirements
- R1: Mode register fields: `mode_op_i[2:0]` selects the length (000=1, 001=2, 010=4, 011=8, 111=full page of 256 columns), and the reserved codes 100, 101 and 110 give length 1. `mode_op_i[3]` selects the order (0 sequential, 1 interleaved). The fields are latched on a clock with `mode_load_i` high. After reset the length is 1 and the order is sequential.
- R2: In the cycle after a clock with `start_i` high, `col_valid_o` is 1 and `col_o` equals the loaded start column. One new column follows on each later clock.
- R3: In a sequential fixed burst of length N, beat k gives low log2(N) bits = (start + k) mod N while the upper bits keep the start value. Exactly N beats are produced.
- R4: In an interleaved fixed burst of length N, beat k gives low log2(N) bits = start XOR k while the upper bits are kept.
- R5: A full-page burst is always sequential, whatever the order bit. It counts up by one per beat, wraps from 255 to 0, and continues until it is stopped or restarted.
- R6: A clock with `stop_i` high during a burst makes `col_valid_o` low in the next cycle, for both fixed and full-page bursts. When `start_i` is high in the same clock, the new burst wins.
- R7: A `start_i` during an active burst restarts at the new column, with the new read/write flag, on the next clock.
- R8: Length, order and write-single mode are captured at `start_i`. A mode load during a burst does not change that burst.
- R9: `wr_byte_en_o[b]` = `col_valid_o` AND write burst AND NOT `dqm_i[b]` in the same cycle. Bit b covers data bits 8b+7:8b. It is all zero during read bursts and when no burst is active.
- R10: `rd_oe_o[b]` = `rd_drive_i` AND NOT the value of `dqm_i[b]` captured at clock edge E, in the cycle that begins at edge E+2. After reset every lane counts as masked.
- R11: `ap_req_o` pulses for one cycle, in the cycle after the last beat, when a fixed-length burst that was loaded with `start_ap_i` high ends on its own. It never pulses for full-page, stopped or restarted bursts.
- R12: With `mode_op_i[9]` set, write bursts have length 1 and read bursts keep the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_load_i | input | 1 | Latch mode fields from `mode_op_i` |
| mode_op_i | input | 11 | Mode register opcode |
| start_i | input | 1 | Load a new burst |
| start_write_i | input | 1 | New burst is a write |
| start_ap_i | input | 1 | New burst requests auto precharge |
| start_col_i | input | 8 | Start column |
| stop_i | input | 1 | Burst terminate or precharge seen |
| dqm_i | input | 4 | Byte mask, one bit per byte lane |
| rd_drive_i | input | 1 | Read data window from the read pipeline |
| col_o | output | 8 | Current column |
| col_valid_o | output | 1 | A burst beat is active |
| col_write_o | output | 1 | Current beat belongs to a write |
| wr_byte_en_o | output | 4 | Per-lane write enable |
| rd_oe_o | output | 4 | Per-lane read output enable |
| ap_req_o | output | 1 | Auto-precharge request after natural completion |

## Verification
The checker assumes that every input changes only between rising edges and that `stop_i` has meaning only while a burst is active. It also assumes that the mask history it compares against starts being counted only after reset is released. The stimulus drives all inputs just after the falling edge. Bursts are started only from an idle or active state that the bench itself tracks. The read-enable sequence is checked only once three mask values have been driven since the pattern began.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int MR_LEN_LSB     = 0;
  localparam int MR_ORD_BIT     = 3;
  localparam int MR_WSINGLE_BIT = 9;

  typedef enum logic {
    ORD_SEQ  = 1'b0,
    ORD_INTL = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic         full;
    burst_order_e order;
    logic         wr_single;
  } burst_cfg_t;
endpackage

// File: rtl/sdram_mode_decode.sv
module sdram_mode_decode
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int OP_W  = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [COL_W-1:0] len_mask_o,
  output burst_cfg_t       cfg_o
);
  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic [2:0]       len_code;
  logic             unused_op_bits;

  assign len_code = op_i[MR_LEN_LSB +: 3];
  assign unused_op_bits = ^{op_i[OP_W-1:MR_WSINGLE_BIT+1],
                            op_i[MR_WSINGLE_BIT-1:MR_ORD_BIT+1]};

  always_comb begin
    mask_d = '0;
    full_d = 1'b0;
    case (len_code)
      3'b000, 3'b001, 3'b010, 3'b011: begin
        for (int i = 0; i < COL_W; i++) mask_d[i] = (i < int'(len_code[1:0]));
      end
      3'b111: begin
        mask_d = '1;
        full_d = 1'b1;
      end
      default: mask_d = '0;  // reserved lengths fall back to a single beat
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_mask_o <= '0;
      cfg_o      <= '{full: 1'b0, order: ORD_SEQ, wr_single: 1'b0};
    end else if (load_i) begin
      len_mask_o      <= mask_d;
      cfg_o.full      <= full_d;
      cfg_o.order     <= burst_order_e'(op_i[MR_ORD_BIT]);
      cfg_o.wr_single <= op_i[MR_WSINGLE_BIT];
    end
  end
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_wr_i,
  input  logic             start_ap_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] len_mask_i,
  input  burst_cfg_t       cfg_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             write_o,
  output logic             ap_req_o,
  output logic [COL_W-1:0] cur_mask_o,
  output logic             cur_full_o
);
  logic             active_q, full_q, intl_q, wr_q, ap_q, ap_req_q;
  logic [COL_W-1:0] beat_q, base_q, mask_q;
  logic [COL_W-1:0] low_bits;
  logic             last_beat, single_wr;

  assign single_wr = start_wr_i && cfg_i.wr_single;
  assign last_beat = !full_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      intl_q   <= 1'b0;
      wr_q     <= 1'b0;
      ap_q     <= 1'b0;
      ap_req_q <= 1'b0;
    end else begin
      ap_req_q <= active_q && !start_i && !stop_i && last_beat && ap_q;
      if (start_i) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        base_q   <= start_col_i;
        mask_q   <= single_wr ? '0 : len_mask_i;
        full_q   <= cfg_i.full && !single_wr;
        intl_q   <= (cfg_i.order == ORD_INTL) && !cfg_i.full;
        wr_q     <= start_wr_i;
        ap_q     <= start_ap_i;
      end else if (active_q) begin
        if (stop_i || last_beat) active_q <= 1'b0;
        else                     beat_q   <= beat_q + 1'b1;
      end
    end
  end

  // low bits wrap inside the aligned block; full page uses an all-ones mask
  assign low_bits   = intl_q ? (base_q ^ beat_q) : (base_q + beat_q);
  assign col_o      = (base_q & ~mask_q) | (low_bits & mask_q);
  assign valid_o    = active_q;
  assign write_o    = active_q && wr_q;
  assign ap_req_o   = ap_req_q;
  assign cur_mask_o = mask_q;
  assign cur_full_o = full_q;
endmodule

// File: rtl/sdram_byte_mask.sv
module sdram_byte_mask #(
  parameter int BYTES  = 4,
  parameter int RD_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BYTES-1:0] dqm_i,
  input  logic             beat_wr_i,
  input  logic             rd_drive_i,
  output logic [BYTES-1:0] wr_be_o,
  output logic [BYTES-1:0] rd_oe_o
);
  // capture stage plus RD_LAT delay stages
  localparam int PIPE_D = RD_LAT + 1;

  logic [BYTES-1:0] pipe_q [PIPE_D];

  for (genvar g = 0; g < PIPE_D; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pipe_q[g] <= '1;
      else if (g == 0) pipe_q[g] <= dqm_i;
      else             pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
    end
  end

  assign wr_be_o = {BYTES{beat_wr_i}} & ~dqm_i;
  assign rd_oe_o = {BYTES{rd_drive_i}} & ~pipe_q[PIPE_D-1];
endmodule

// File: rtl/sdram_burst_colmask.sv
module sdram_burst_colmask
  import sdram_burst_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int OP_W   = 11,
  parameter int RD_LAT = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mode_load_i,
  input  logic [OP_W-1:0]           mode_op_i,
  input  logic                      start_i,
  input  logic                      start_write_i,
  input  logic                      start_ap_i,
  input  logic [COL_W-1:0]          start_col_i,
  input  logic                      stop_i,
  input  logic [DATA_W/BYTE_W-1:0]  dqm_i,
  input  logic                      rd_drive_i,
  output logic [COL_W-1:0]          col_o,
  output logic                      col_valid_o,
  output logic                      col_write_o,
  output logic [DATA_W/BYTE_W-1:0]  wr_byte_en_o,
  output logic [DATA_W/BYTE_W-1:0]  rd_oe_o,
  output logic                      ap_req_o
);
  localparam int BYTES = DATA_W / BYTE_W;

  logic [COL_W-1:0] len_mask;
  burst_cfg_t       cfg;
  logic [COL_W-1:0] cur_mask;
  logic             cur_full;

  sdram_mode_decode #(.COL_W(COL_W), .OP_W(OP_W)) i_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mode_load_i),
    .op_i       (mode_op_i),
    .len_mask_o (len_mask),
    .cfg_o      (cfg)
  );

  sdram_col_gen #(.COL_W(COL_W)) i_col (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_wr_i  (start_write_i),
    .start_ap_i  (start_ap_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .len_mask_i  (len_mask),
    .cfg_i       (cfg),
    .col_o       (col_o),
    .valid_o     (col_valid_o),
    .write_o     (col_write_o),
    .ap_req_o    (ap_req_o),
    .cur_mask_o  (cur_mask),
    .cur_full_o  (cur_full)
  );

  sdram_byte_mask #(.BYTES(BYTES), .RD_LAT(RD_LAT)) i_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dqm_i      (dqm_i),
    .beat_wr_i  (col_write_o),
    .rd_drive_i (rd_drive_i),
    .wr_be_o    (wr_byte_en_o),
    .rd_oe_o    (rd_oe_o)
  );
endmodule

// File: rtl/sdram_burst_colmask_chk.sv
module sdram_burst_colmask_chk #(
  parameter int COL_W  = 8,
  parameter int BYTES  = 4,
  parameter int RD_LAT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [BYTES-1:0] dqm_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_valid_o,
  input logic [BYTES-1:0] wr_byte_en_o,
  input logic [BYTES-1:0] rd_oe_o,
  input logic             ap_req_o,
  input logic [COL_W-1:0] cur_mask_i,
  input logic             cur_full_i
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assert_start_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 0 && $past(start_i)) |-> (col_valid_o && col_o == $past(start_col_i)));

  assert_block_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 0 && col_valid_o && $past(col_valid_o) && !$past(start_i) && !cur_full_i)
      |-> $stable(col_o & ~cur_mask_i));

  assert_page_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 0 && col_valid_o && $past(col_valid_o) && !$past(start_i) && cur_full_i)
      |-> (col_o == $past(col_o) + 1'b1));

  assert_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 0 && $past(stop_i && !start_i)) |-> !col_valid_o);

  assert_wr_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_byte_en_o & dqm_i) == '0) && (wr_byte_en_o == '0 || col_valid_o));

  if (RD_LAT == 2) begin : g_rd_chk
    assert_rd_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q == 2'd3) |-> ((rd_oe_o & $past(dqm_i, 3)) == '0));
  end

  assert_ap_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 0 && ap_req_o) |-> (!col_valid_o && $past(col_valid_o) && !cur_full_i));
endmodule

bind sdram_burst_colmask sdram_burst_colmask_chk #(
  .COL_W(COL_W), .BYTES(BYTES), .RD_LAT(RD_LAT)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_col_i  (start_col_i),
  .stop_i       (stop_i),
  .dqm_i        (dqm_i),
  .col_o        (col_o),
  .col_valid_o  (col_valid_o),
  .wr_byte_en_o (wr_byte_en_o),
  .rd_oe_o      (rd_oe_o),
  .ap_req_o     (ap_req_o),
  .cur_mask_i   (cur_mask),
  .cur_full_i   (cur_full)
);

// File: tb/test_sdram_burst_colmask.sv
module test_sdram_burst_colmask;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_load_i = 1'b0;
  logic [10:0] mode_op_i = '0;
  logic        start_i = 1'b0;
  logic        start_write_i = 1'b0;
  logic        start_ap_i = 1'b0;
  logic [7:0]  start_col_i = '0;
  logic        stop_i = 1'b0;
  logic [3:0]  dqm_i = '0;
  logic        rd_drive_i = 1'b0;
  logic [7:0]  col_o;
  logic        col_valid_o, col_write_o, ap_req_o;
  logic [3:0]  wr_byte_en_o, rd_oe_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  sdram_burst_colmask i_sdram_burst_colmask (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_col(input logic [7:0] s, input int n, input bit intl, input int k);
    int off, low;
    off = int'(s) % n;
    low = intl ? (off ^ k) : ((off + k) % n);
    return 8'(int'(s) - off + low);
  endfunction

  task automatic load_mode(input logic [10:0] op);
    mode_load_i = 1'b1; mode_op_i = op;
    @(negedge clk_i);
    mode_load_i = 1'b0;
  endtask

  task automatic start_burst(input logic [7:0] col, input bit wr, input bit ap);
    start_i = 1'b1; start_col_i = col; start_write_i = wr; start_ap_i = ap;
    @(negedge clk_i);
    start_i = 1'b0; start_write_i = 1'b0; start_ap_i = 1'b0;
  endtask

  task automatic beat(input logic [7:0] exp, input bit wr, input string req, input logic [3:0] dq);
    dqm_i = dq;
    #1;
    chk(col_valid_o === 1'b1, req, 32'(col_valid_o), 1);
    chk(col_o === exp, req, 32'(col_o), 32'(exp));
    chk(col_write_o === wr, req, 32'(col_write_o), 32'(wr));
    chk(wr_byte_en_o === (wr ? ~dq : 4'h0), "R9", 32'(wr_byte_en_o), 32'(wr ? ~dq : 4'h0));
    @(negedge clk_i);
  endtask

  task automatic end_check(input bit ap_exp, input string req);
    #1;
    chk(col_valid_o === 1'b0, req, 32'(col_valid_o), 0);
    chk(wr_byte_en_o === 4'h0, "R9", 32'(wr_byte_en_o), 0);
    chk(ap_req_o === ap_exp, "R11", 32'(ap_req_o), 32'(ap_exp));
    @(negedge clk_i);
    #1;
    chk(ap_req_o === 1'b0, "R11", 32'(ap_req_o), 0);
    @(negedge clk_i);
  endtask

  task automatic run_fixed(input logic [7:0] s, input int lg2, input bit intl,
                           input bit wr, input bit ap, input string req);
    int n;
    n = 1 << lg2;
    start_burst(s, wr, ap);
    for (int k = 0; k < n; k++) beat(model_col(s, n, intl, k), wr, req, 4'(k * 3 + 1));
    end_check(ap, req);
  endtask

  task automatic t_reset();
    rd_drive_i = 1'b1; dqm_i = 4'h0;
    #1;
    chk(col_valid_o === 1'b0, "R2 reset", 32'(col_valid_o), 0);
    chk(wr_byte_en_o === 4'h0, "R9 reset", 32'(wr_byte_en_o), 0);
    chk(rd_oe_o === 4'h0, "R10 reset", 32'(rd_oe_o), 0);
    chk(ap_req_o === 1'b0, "R11 reset", 32'(ap_req_o), 0);
    rd_drive_i = 1'b0;
    @(negedge clk_i);
    run_fixed(8'h44, 0, 0, 1'b0, 1'b0, "R1 reset length 1");
  endtask

  task automatic t_orders();
    load_mode(11'h002);
    run_fixed(8'h5E, 2, 0, 1'b1, 1'b0, "R3 seq4");
    load_mode(11'h003);
    run_fixed(8'h35, 3, 0, 1'b0, 1'b0, "R3 seq8");
    load_mode(11'h00B);
    run_fixed(8'h35, 3, 1, 1'b0, 1'b0, "R4 intl8");
    load_mode(11'h00A);
    run_fixed(8'hA6, 2, 1, 1'b1, 1'b0, "R4 intl4");
    load_mode(11'h001);
    run_fixed(8'h81, 1, 0, 1'b1, 1'b0, "R3 seq2");
    load_mode(11'h000);
    run_fixed(8'h7F, 0, 0, 1'b0, 1'b0, "R1 len1");
  endtask

  task automatic t_reserved();
    load_mode(11'h005);
    run_fixed(8'h92, 0, 0, 1'b1, 1'b0, "R1 reserved 101");
    load_mode(11'h00E);
    run_fixed(8'h17, 0, 0, 1'b0, 1'b0, "R1 reserved 110");
  endtask

  task automatic t_autopre();
    load_mode(11'h002);
    run_fixed(8'h13, 2, 0, 1'b1, 1'b1, "R11 ap len4");
    load_mode(11'h000);
    run_fixed(8'hC0, 0, 0, 1'b0, 1'b1, "R11 ap len1");
  endtask

  task automatic t_wr_single();
    load_mode(11'h202);
    run_fixed(8'h66, 0, 0, 1'b1, 1'b1, "R12 single write");
    run_fixed(8'h66, 2, 0, 1'b0, 1'b0, "R12 read keeps length");
  endtask

  task automatic t_full_page();
    load_mode(11'h00F);  // full page with order bit set: still sequential
    start_burst(8'hFC, 1'b1, 1'b1);
    for (int k = 0; k < 300; k++) beat(model_col(8'hFC, 256, 0, k), 1'b1, "R5 wrap", 4'(k));
    stop_i = 1'b1;
    beat(model_col(8'hFC, 256, 0, 300), 1'b1, "R5 wrap", 4'h5);
    stop_i = 1'b0;
    end_check(1'b0, "R6 page stop");
  endtask

  task automatic t_stop_fixed();
    load_mode(11'h003);
    start_burst(8'h10, 1'b0, 1'b1);
    beat(8'h10, 1'b0, "R3 pre-stop", 4'h0);
    beat(8'h11, 1'b0, "R3 pre-stop", 4'h0);
    stop_i = 1'b1;
    beat(8'h12, 1'b0, "R6 stop beat", 4'h0);
    stop_i = 1'b0;
    end_check(1'b0, "R6 fixed stop");
  endtask

  task automatic t_restart();
    load_mode(11'h003);
    start_burst(8'h20, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) beat(model_col(8'h20, 8, 0, k), 1'b0, "R7 first", 4'h0);
    start_i = 1'b1; start_col_i = 8'h47; start_write_i = 1'b1; stop_i = 1'b1;
    beat(8'h23, 1'b0, "R7 first", 4'h0);
    start_i = 1'b0; start_write_i = 1'b0; stop_i = 1'b0;
    for (int k = 0; k < 8; k++) beat(model_col(8'h47, 8, 0, k), 1'b1, "R7 restart R6 start wins", 4'(k + 8));
    end_check(1'b0, "R7 restart end");
  endtask

  task automatic t_mode_mid();
    load_mode(11'h002);
    start_burst(8'h00, 1'b1, 1'b0);
    beat(8'h00, 1'b1, "R8 held", 4'h3);
    mode_load_i = 1'b1; mode_op_i = 11'h003;
    beat(8'h01, 1'b1, "R8 held", 4'h0);
    mode_load_i = 1'b0;
    beat(8'h02, 1'b1, "R8 held", 4'hC);
    beat(8'h03, 1'b1, "R8 held", 4'hF);
    end_check(1'b0, "R8 length kept");
    run_fixed(8'h00, 3, 0, 1'b0, 1'b0, "R8 next burst uses new mode");
  endtask

  task automatic t_rd_oe();
    logic [3:0] d [12];
    for (int j = 0; j < 12; j++) d[j] = 4'((j * 7 + 3) ^ (j >> 1));
    rd_drive_i = 1'b1;
    for (int j = 0; j < 12; j++) begin
      dqm_i = d[j];
      #1;
      if (j >= 3) chk(rd_oe_o === ~d[j-3], "R10 latency", 32'(rd_oe_o), 32'(~d[j-3]));
      @(negedge clk_i);
    end
    rd_drive_i = 1'b0;
    dqm_i = 4'h0;
    #1;
    chk(rd_oe_o === 4'h0, "R10 drive low", 32'(rd_oe_o), 0);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_orders();
    t_reserved();
    t_autopre();
    t_wr_single();
    t_full_page();
    t_stop_fixed();
    t_restart();
    t_mode_mid();
    t_rd_oe();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule